// File: doc/BRIEF.md
# Interrupt Slot Routing Arbiter

This block decides which source drives each interrupt slot of a serial interrupt frame. Two kinds of source compete. The first is a set of internal devices. Each has a 4-bit slot number, an activate bit that belongs to its logical device and, for some devices, an enable bit. The second is four external interrupt inputs, each with its own 4-bit slot number. The block resolves ownership slot by slot and presents a 16-bit request vector to the frame generator. Bit N of that vector is the interrupt level of whichever source owns slot N.

An internal device claims a slot only when all of these hold: its logical device is activated, it is enabled, and its slot number is nonzero. A device without an enable bit counts as enabled when it is activated and has a nonzero slot. A claimed slot shuts out every external input programmed to the same number. A slot that no internal device claims carries the OR of the external inputs that select it. The routing logic is combinational, and the result is captured in one output register.

Default device map, by index: 0 to 4 are devices with an enable bit (floppy, two serial ports, parallel port, management bus). Device 5 is the keyboard, device 6 is the mouse and device 7 is the watchdog. Activate bits 0 to 4 belong to devices 0 to 4. Activate bit 5 is shared by the keyboard and the mouse. Activate bit 6 belongs to the watchdog.

Top module: `irq_slot_router`

## Requirements
- R1: `slot_req` is registered. A change at the inputs appears at the output one rising edge later and not before. While `rst` is high at an edge, `slot_req` is cleared to 0.
- R2: External input e, with a nonzero slot number s in `ext_sel[4e+3:4e]`, drives `slot_req[s]` with `ext_irq[e]` when no internal device claims slot s.
- R3: An external input whose slot number is 0 drives no bit of `slot_req`.
- R4: Device d in 0..4 claims its slot s, taken from `dev_sel[4d+3:4d]`, when s is nonzero, `dev_act[d]` is 1 and `dev_en[d]` is 1. Bit s then equals `dev_irq[d]`, and any external input on slot s is blocked.
- R5: Device d in 0..4 with slot s selected and `dev_en[d]` = 0 does not claim slot s. An external input on slot s then reaches `slot_req[s]`.
- R6: A device whose activate bit is 0 claims no slot, even when its enable bit is 1.
- R7: Devices 5, 6 and 7 have no enable bit. Each claims its nonzero slot whenever its activate bit is 1, and `dev_en[7:5]` has no effect.
- R8: The keyboard (device 5) and the mouse (device 6) both take their activate bit from `dev_act[5]`. Device 7 takes its activate bit from `dev_act[6]`.
- R9: Two or more external inputs on the same unclaimed slot are ORed onto that slot.
- R10: A device with slot number 0 claims no slot and blocks nothing. `slot_req[0]` is always 0.
- R11: Two or more claiming internal devices on the same slot are ORed onto that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sel | input | 16 | Slot numbers of the external inputs, 4 bits each, input e at bits 4e+3:4e |
| ext_irq | input | 4 | Levels of the external inputs |
| dev_sel | input | 32 | Slot numbers of the internal devices, 4 bits each, device d at bits 4d+3:4d |
| dev_act | input | 7 | Activate bits of the logical devices |
| dev_en | input | 8 | Enable bits; bits 7:5 are ignored |
| dev_irq | input | 8 | Levels of the internal devices |
| slot_req | output | 16 | Registered per-slot request vector |

## Verification
The hardest case to reach is a slot contested by three kinds of source at the same time. Those are an internal device that is selected but fails one of its qualifiers, a second device that does qualify, and an external input on the same number. In this case the output bit shows which source won only when the levels of the competing sources differ. The stimulus therefore sweeps every slot number against every combination of activate, enable, device level and external level, for each device class. The shared activate bit is tested with the other activate bit toggled against it. A long pseudo-random run over the full register set then checks against an arithmetic model of the ownership rules.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DEF_SLOT_W  = 4;
  localparam int DEF_NUM_EXT = 4;
  localparam int DEF_NUM_DEV = 8;
  localparam int DEF_NUM_LD  = 7;
  localparam int DEF_LD_W    = $clog2(DEF_NUM_LD);
  // devices 0..4 carry an enable bit, 5..7 do not
  localparam logic [DEF_NUM_DEV-1:0] DEF_HAS_EN = 8'b0001_1111;
  // device -> logical device index, device 0 in the low field
  localparam logic [DEF_NUM_DEV*DEF_LD_W-1:0] DEF_LD_MAP =
    {3'd6, 3'd5, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
endpackage

// File: rtl/irq_slot_decode.sv
module irq_slot_decode #(
  parameter int SLOT_W = 4
) (
  input  logic [SLOT_W-1:0]      sel,
  input  logic                   live,
  output logic [(1<<SLOT_W)-1:0] hit
);
  always_comb begin
    hit = '0;
    // slot number zero means unassigned
    if (live && (sel != '0)) hit[sel] = 1'b1;
  end
endmodule

// File: rtl/irq_dev_qualify.sv
module irq_dev_qualify #(
  parameter int NUM_DEV = 8,
  parameter int NUM_LD  = 7,
  parameter logic [NUM_DEV-1:0] HAS_EN_MASK = 8'b0001_1111,
  parameter logic [NUM_DEV*$clog2(NUM_LD)-1:0] DEV_LD_MAP = 24'hD6C688
) (
  input  logic [NUM_LD-1:0]  dev_act,
  input  logic [NUM_DEV-1:0] dev_en,
  output logic [NUM_DEV-1:0] dev_live
);
  localparam int LD_W = $clog2(NUM_LD);

  // enable bits of devices without one are never looked at
  logic unused_en;
  assign unused_en = ^(dev_en & ~HAS_EN_MASK);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam int LDI = int'(DEV_LD_MAP[d*LD_W +: LD_W]);
    if (HAS_EN_MASK[d]) begin : g_gated
      assign dev_live[d] = dev_act[LDI] & dev_en[d];
    end else begin : g_plain
      assign dev_live[d] = dev_act[LDI];
    end
  end
endmodule

// File: rtl/irq_slot_merge.sv
module irq_slot_merge #(
  parameter int NUM_SRC = 4,
  parameter int NS      = 16
) (
  input  logic [NUM_SRC-1:0][NS-1:0] hit,
  input  logic [NUM_SRC-1:0]         lvl,
  output logic [NS-1:0]              claim,
  output logic [NS-1:0]              level
);
  always_comb begin
    claim = '0;
    level = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      claim = claim | hit[i];
      level = level | (hit[i] & {NS{lvl[i]}});
    end
  end
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irq_route_pkg::*;
#(
  parameter int SLOT_W  = DEF_SLOT_W,
  parameter int NUM_EXT = DEF_NUM_EXT,
  parameter int NUM_DEV = DEF_NUM_DEV,
  parameter int NUM_LD  = DEF_NUM_LD,
  parameter logic [NUM_DEV-1:0] HAS_EN_MASK = DEF_HAS_EN,
  parameter logic [NUM_DEV*$clog2(NUM_LD)-1:0] DEV_LD_MAP = DEF_LD_MAP
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_EXT*SLOT_W-1:0]   ext_sel,
  input  logic [NUM_EXT-1:0]          ext_irq,
  input  logic [NUM_DEV*SLOT_W-1:0]   dev_sel,
  input  logic [NUM_LD-1:0]           dev_act,
  input  logic [NUM_DEV-1:0]          dev_en,
  input  logic [NUM_DEV-1:0]          dev_irq,
  output logic [(1<<SLOT_W)-1:0]      slot_req
);
  localparam int NS = 1 << SLOT_W;

  logic [NUM_DEV-1:0]          dev_live;
  logic [NUM_DEV-1:0][NS-1:0]  dev_hit;
  logic [NUM_EXT-1:0][NS-1:0]  ext_hit;
  logic [NS-1:0] int_claim, int_level;
  logic [NS-1:0] ext_claim, ext_level;
  logic [NS-1:0] slot_next;

  irq_dev_qualify #(
    .NUM_DEV(NUM_DEV), .NUM_LD(NUM_LD),
    .HAS_EN_MASK(HAS_EN_MASK), .DEV_LD_MAP(DEV_LD_MAP)
  ) qual_i (
    .dev_act(dev_act), .dev_en(dev_en), .dev_live(dev_live)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev_dec
    irq_slot_decode #(.SLOT_W(SLOT_W)) dec_i (
      .sel(dev_sel[d*SLOT_W +: SLOT_W]), .live(dev_live[d]), .hit(dev_hit[d])
    );
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext_dec
    irq_slot_decode #(.SLOT_W(SLOT_W)) dec_i (
      .sel(ext_sel[e*SLOT_W +: SLOT_W]), .live(1'b1), .hit(ext_hit[e])
    );
  end

  irq_slot_merge #(.NUM_SRC(NUM_DEV), .NS(NS)) int_merge_i (
    .hit(dev_hit), .lvl(dev_irq), .claim(int_claim), .level(int_level)
  );

  irq_slot_merge #(.NUM_SRC(NUM_EXT), .NS(NS)) ext_merge_i (
    .hit(ext_hit), .lvl(ext_irq), .claim(ext_claim), .level(ext_level)
  );

  // an external claim matters only through its level
  logic unused_ext_claim;
  assign unused_ext_claim = ^ext_claim;

  // internal ownership blocks the external path slot by slot
  assign slot_next = (int_claim & int_level) | (~int_claim & ext_level);

  always_ff @(posedge clk) begin
    if (rst) slot_req <= '0;
    else     slot_req <= slot_next;
  end
endmodule

// File: rtl/irq_slot_router_chk.sv
module irq_slot_router_chk #(
  parameter int SLOT_W  = 4,
  parameter int NUM_EXT = 4,
  parameter int NUM_DEV = 8,
  parameter int NUM_LD  = 7
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_EXT*SLOT_W-1:0] ext_sel,
  input logic [NUM_EXT-1:0]        ext_irq,
  input logic [NUM_LD-1:0]         dev_act,
  input logic [NUM_DEV-1:0]        dev_irq,
  input logic [(1<<SLOT_W)-1:0]    slot_req
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (slot_req == '0));

  p_slot0_idle_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    slot_req[0] == 1'b0);

  p_inactive_silent_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ext_irq) == '0 && $past(dev_act) == '0) |-> (slot_req == '0));

  p_ext_unassigned_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ext_sel) == '0 && $past(dev_irq) == '0) |-> (slot_req == '0));
endmodule

bind irq_slot_router irq_slot_router_chk #(
  .SLOT_W(SLOT_W), .NUM_EXT(NUM_EXT), .NUM_DEV(NUM_DEV), .NUM_LD(NUM_LD)
) chk_i (.*);

// File: tb/irq_slot_router_tb.sv
module irq_slot_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_sel = '0;
  logic [3:0]  ext_irq = '0;
  logic [31:0] dev_sel = '0;
  logic [6:0]  dev_act = '0;
  logic [7:0]  dev_en  = '0;
  logic [7:0]  dev_irq = '0;
  logic [15:0] slot_req;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_slot_router dut_i (
    .clk(clk), .rst(rst), .ext_sel(ext_sel), .ext_irq(ext_irq),
    .dev_sel(dev_sel), .dev_act(dev_act), .dev_en(dev_en),
    .dev_irq(dev_irq), .slot_req(slot_req)
  );

  function automatic logic [15:0] model(
    logic [15:0] es, logic [3:0] ei, logic [31:0] ds,
    logic [6:0] da, logic [7:0] de, logic [7:0] di);
    logic [15:0] cl, il, el;
    cl = '0; il = '0; el = '0;
    for (int d = 0; d < 8; d++) begin
      logic a, live;
      logic [3:0] s;
      a = (d < 5) ? da[d] : (d < 7) ? da[5] : da[6];
      live = a && (d >= 5 || de[d]);
      s = ds[4*d +: 4];
      if (live && s != 0) begin
        cl[s] = 1'b1;
        if (di[d]) il[s] = 1'b1;
      end
    end
    for (int e = 0; e < 4; e++) begin
      logic [3:0] s;
      s = es[4*e +: 4];
      if (s != 0 && ei[e]) el[s] = 1'b1;
    end
    return (cl & il) | (~cl & el);
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    tests++;
    if (slot_req !== exp) begin
      fails++;
      $display("FAIL %s: slot_req=%h expected=%h", tag, slot_req, exp);
    end
  endtask

  task automatic clear_cfg();
    ext_sel = '0; ext_irq = '0; dev_sel = '0;
    dev_act = '0; dev_en = '0; dev_irq = '0;
  endtask

  // inputs were set away from the edge; one edge later the output holds them
  task automatic step(string tag, logic [15:0] exp);
    @(posedge clk); #1;
    check(tag, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // R1 reset clears even with an active source
    ext_sel = 16'h0003; ext_irq = 4'h1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset", 16'h0000);
    rst = 1'b0;
    step("R1 first cycle", 16'h0008);
    ext_irq = 4'h0; #1;
    check("R1 no early change", 16'h0008);
    step("R1 one edge later", 16'h0000);

    // R2 / R3 single external input sweep
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 16; s++)
        for (int l = 0; l < 2; l++) begin
          clear_cfg();
          ext_sel[4*e +: 4] = 4'(s); ext_irq[e] = 1'(l);
          step(s == 0 ? "R3" : "R2", (s != 0 && l == 1) ? (16'h1 << s) : 16'h0);
        end

    // R4 / R5 / R6 devices with enable bits
    for (int d = 0; d < 5; d++)
      for (int s = 1; s < 16; s++)
        for (int c = 0; c < 16; c++) begin
          logic a, en, di, ei, own;
          a = c[0]; en = c[1]; di = c[2]; ei = c[3];
          own = a && en;
          clear_cfg();
          dev_sel[4*d +: 4] = 4'(s); dev_act[d] = a; dev_en[d] = en;
          dev_irq[d] = di; ext_sel[3:0] = 4'(s); ext_irq[0] = ei;
          step(own ? "R4" : (!a ? "R6" : "R5"),
               (own ? 16'(di) : 16'(ei)) << s);
        end

    // R7 / R8 devices without enable bits, shared activate bit
    for (int d = 5; d < 8; d++)
      for (int s = 1; s < 16; s++)
        for (int c = 0; c < 32; c++) begin
          logic b5, b6, en, di, ei, own;
          b5 = c[0]; b6 = c[1]; en = c[2]; di = c[3]; ei = c[4];
          own = (d < 7) ? b5 : b6;
          clear_cfg();
          dev_sel[4*d +: 4] = 4'(s); dev_act[5] = b5; dev_act[6] = b6;
          dev_en[d] = en; dev_irq[d] = di;
          ext_sel[7:4] = 4'(s); ext_irq[1] = ei;
          step(d < 7 ? "R8" : "R7", (own ? 16'(di) : 16'(ei)) << s);
        end

    // R9 two external inputs on one slot
    for (int s = 1; s < 16; s++)
      for (int c = 0; c < 4; c++) begin
        clear_cfg();
        ext_sel[3:0] = 4'(s); ext_sel[11:8] = 4'(s);
        ext_irq[0] = c[0]; ext_irq[2] = c[1];
        step("R9", 16'(c[0] | c[1]) << s);
      end

    // R10 device on slot zero blocks nothing
    clear_cfg();
    dev_act = 7'h7F; dev_en = 8'hFF; dev_irq = 8'hFF;
    ext_sel = 16'h0005; ext_irq = 4'h1;
    step("R10 zero slot", 16'h0020);
    ext_sel = 16'h0000;
    step("R10 bit0", 16'h0000);

    // R11 two claiming devices share a slot, external blocked
    for (int s = 1; s < 16; s++)
      for (int c = 0; c < 4; c++) begin
        clear_cfg();
        dev_sel[3:0] = 4'(s); dev_sel[7:4] = 4'(s);
        dev_act[1:0] = 2'b11; dev_en[1:0] = 2'b11;
        dev_irq[0] = c[0]; dev_irq[1] = c[1];
        ext_sel[15:12] = 4'(s); ext_irq[3] = 1'b1;
        step("R11", 16'(c[0] | c[1]) << s);
      end

    // mixed pseudo-random configurations against the model
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      ext_sel = lfsr[15:0]; ext_irq = lfsr[19:16]; dev_act = lfsr[26:20];
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      dev_sel = lfsr;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      dev_en = lfsr[7:0]; dev_irq = lfsr[15:8];
      step("R4 mixed", model(ext_sel, ext_irq, dev_sel, dev_act, dev_en, dev_irq));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule